// File: doc/BRIEF.md
# Frame-Pulse Watchdog Timer

This block supervises software by counting frame pulses. A counter of a parameterised number of stages (eleven by default) advances once for every frame pulse that arrives on an asynchronous input. The pulse is brought into the system clock domain by a synchronizer and turned into a single-cycle tick by an edge detector. Software keeps the watchdog from expiring by writing a key value through an 8-bit write port. Only the low five bits of the write data are compared, with the key value binary 01010. The upper three bits may hold anything. Writes of any other value have no effect.

The counter is kept as a two-state machine plus a lower counter of ten bits. The states are ARMED, where the output is high, and EXPIRED, where the output is low. The lower counter counts frame ticks. When it wraps while in ARMED, the transition TIMEOUT moves to EXPIRED. When it wraps while in EXPIRED, the transition RECOVER moves back to ARMED. A key write takes the transition KICK from either state: it goes to ARMED and zeroes the lower counter. Together this is exactly an eleven-stage binary counter whose output is the inverted top stage. So after 1024 unkicked frame pulses the output drops, and it stays low for another 1024 pulses. Asserting the active-low reset clears everything and forces the output low for as long as the reset is held.

Top module: `fp_watchdog`

## Requirements
- R1: Each rising edge of `frame_pulse` advances the count exactly once, however many clock cycles the pulse stays high.
- R2: A write (`wr_en` high) whose `wr_data[4:0]` equals 5'b01010 clears the count, regardless of `wr_data[7:5]`. `wd_n` is high from the clock after the write, even if it was low.
- R3: A write whose `wr_data[4:0]` differs from 5'b01010 neither clears nor alters the count.
- R4: After reset or a key write, `wd_n` stays high through 1023 frame pulses and goes low on the 1024th.
- R5: Once low through expiry, `wd_n` stays low for exactly 1024 frame pulses, then returns high and a new timeout period begins.
- R6: While `rst_n` is low, `wd_n` is low. Reset clears the count to zero.
- R7: `wd_n` changes only after a frame tick or a key write, except when reset is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_pulse | input | 1 | Asynchronous frame pulse; each rising edge is one count |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 8 | Write data; low five bits compared with the key |
| wd_n | output | 1 | Watchdog output, high while healthy, low on expiry or in reset |

## Verification
The checker watches several behaviours on every cycle. The frame tick is a single-cycle pulse. `wd_n` moves only after a tick or a key write. A key write always leaves `wd_n` high. A non-key write with no tick leaves `wd_n` unchanged. `wd_n` is low whenever reset is held. The exact 1024-pulse timeout and the 1024-pulse low window are shown only by the bench. It counts pulses with its own model and compares `wd_n` after every pulse and write. The bench scenarios also cover long-held pulses, key writes with varied upper bits during the low window, and reset applied mid-count.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic {
        ST_ARMED   = 1'b0,
        ST_EXPIRED = 1'b1
    } wdt_state_t;
endpackage

// File: rtl/wdt_fp_edge.sv
module wdt_fp_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_in,
    output logic tick
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] shift_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else begin
            shift_q <= {shift_q[SH_W-2:0], pulse_in};
        end
    end

    // rising edge of the synchronized level
    assign tick = shift_q[SYNC_STAGES-1] & ~shift_q[SYNC_STAGES];
endmodule

// File: rtl/wdt_key_match.sv
module wdt_key_match #(
    parameter int          DATA_W = 8,
    parameter int          KEY_W  = 5,
    parameter logic [KEY_W-1:0] KEY = 5'b01010
) (
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              kick
);
    localparam logic [DATA_W-1:0] MASK    = DATA_W'((1 << KEY_W) - 1);
    localparam logic [DATA_W-1:0] KEY_EXT = DATA_W'(KEY);

    assign kick = wr_en && ((wr_data & MASK) == KEY_EXT);
endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm
    import wdt_pkg::*;
#(
    parameter int STAGES = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic kick,
    output logic wd_n
);
    localparam int LOW_W = STAGES - 1;
    localparam logic [LOW_W-1:0] LOW_MAX = '1;

    wdt_state_t       state_q, state_d;
    logic [LOW_W-1:0] cnt_q, cnt_d;

    // next-state logic: KICK has priority over a tick in the same cycle
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (kick) begin
            state_d = ST_ARMED;
            cnt_d   = '0;
        end else if (tick) begin
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == LOW_MAX) begin
                unique case (state_q)
                    ST_ARMED:   state_d = ST_EXPIRED;  // TIMEOUT
                    ST_EXPIRED: state_d = ST_ARMED;    // RECOVER
                    default:    state_d = ST_ARMED;
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_ARMED:   wd_n = rst_n;
            ST_EXPIRED: wd_n = 1'b0;
            default:    wd_n = 1'b0;
        endcase
    end
endmodule

// File: rtl/fp_watchdog.sv
module fp_watchdog #(
    parameter int               STAGES      = 11,
    parameter int               SYNC_STAGES = 2,
    parameter int               DATA_W      = 8,
    parameter int               KEY_W       = 5,
    parameter logic [KEY_W-1:0] KEY         = 5'b01010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_pulse,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wd_n
);
    logic fp_tick;
    logic kick;

    wdt_fp_edge #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pulse_in (frame_pulse),
        .tick     (fp_tick)
    );

    wdt_key_match #(.DATA_W(DATA_W), .KEY_W(KEY_W), .KEY(KEY)) key_i (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .kick    (kick)
    );

    wdt_fsm #(.STAGES(STAGES)) fsm_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (fp_tick),
        .kick  (kick),
        .wd_n  (wd_n)
    );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              fp_tick,
    input logic              wd_n
);
    logic key_wr;
    assign key_wr = wr_en && (wr_data[4:0] == 5'b01010);

    assert_single_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fp_tick |=> !fp_tick);

    assert_kick_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        key_wr |=> wd_n);

    assert_bad_key_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !key_wr && !fp_tick) |=> $stable(wd_n));

    assert_fall_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wd_n) |-> $past(fp_tick));

    assert_low_in_reset_R6: assert property (@(posedge clk)
        !rst_n |-> !wd_n);

    assert_quiet_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!fp_tick && !key_wr) |=> $stable(wd_n));
endmodule

bind fp_watchdog wdt_checker #(.DATA_W(DATA_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .fp_tick (fp_tick),
    .wd_n    (wd_n)
);

// File: tb/fp_watchdog_tb.sv
`timescale 1ns/1ps
module fp_watchdog_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_pulse = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wd_n;

    int n_checks = 0;
    int n_fail = 0;
    logic [10:0] model_cnt = '0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fp_watchdog dut_i (
        .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse),
        .wr_en(wr_en), .wr_data(wr_data), .wd_n(wd_n)
    );

    function automatic logic exp_wd(input logic [10:0] c);
        return ~c[10];
    endfunction

    function automatic bit is_key(input logic [7:0] d);
        return d[4:0] == 5'b01010;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: wd_n=%b expected %b (model count %0d)", req, act, exp, model_cnt);
        end
    endtask

    task automatic pulse(input int high_cycles);
        @(negedge clk) frame_pulse = 1'b1;
        repeat (high_cycles) @(negedge clk);
        frame_pulse = 1'b0;
        repeat (4) @(negedge clk);
        model_cnt = model_cnt + 1'b1;
    endtask

    task automatic write(input logic [7:0] d);
        @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
        @(negedge clk) wr_en = 1'b0;
        if (is_key(d)) model_cnt = '0;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) pulse(2);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: bench timed out");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R6 low in reset", wd_n, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 high after reset", wd_n, 1'b1);

        // R4: timeout after 1024 pulses
        pulses(1023);
        check("R4 high at 1023", wd_n, exp_wd(model_cnt));
        pulse(2);
        check("R4 low at 1024", wd_n, 1'b0);
        // R5: low window of 1024 pulses
        pulses(1023);
        check("R5 still low", wd_n, 1'b0);
        pulse(2);
        check("R5 recovers", wd_n, 1'b1);
        check("R5 model agrees", wd_n, exp_wd(model_cnt));

        // R1: long-held pulse counts once
        write(8'h0A);
        pulses(1022);
        pulse(25);
        check("R1 long pulse counted once", wd_n, 1'b1);
        pulse(2);
        check("R1 expiry after long pulse", wd_n, 1'b0);

        // R3: non-key writes while low
        write(8'h0B); check("R3 0x0B ignored", wd_n, 1'b0);
        write(8'h1A); check("R3 0x1A ignored", wd_n, 1'b0);
        write(8'hFF); check("R3 0xFF ignored", wd_n, 1'b0);

        // R2: key with upper bits set while low
        write(8'hEA);
        check("R2 key 0xEA revives", wd_n, 1'b1);
        pulses(1023);
        write(8'h6A);
        check("R2 kick near expiry", wd_n, 1'b1);
        pulses(1023);
        check("R2 timer restarted", wd_n, 1'b1);

        // R6: reset mid-count
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) check("R6 low during reset", wd_n, 1'b0);
        rst_n = 1'b1;
        model_cnt = '0;
        @(negedge clk) check("R6 count cleared", wd_n, 1'b1);
        pulses(1024);
        check("R6 full period after reset", wd_n, 1'b0);

        // random mix, R7 output tracks model only through ticks and keys
        for (int i = 0; i < 2500; i++) begin
            int unsigned r;
            r = $urandom_range(0, 99);
            if (r < 92) begin
                pulse(int'($urandom_range(1, 4)));
            end else begin
                logic [7:0] d;
                d = (r < 95) ? {3'($urandom), 5'b01010} : 8'($urandom);
                write(d);
            end
            check("R7 random", wd_n, exp_wd(model_cnt));
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule